// File: doc/BRIEF.md
# Three-wire serial control register bank

This block is the control port of a frequency synthesizer. A host drives a serial clock line and a data line. Each rising edge of the serial clock moves one data bit into a 20-bit frequency word, least-significant bit first. When the enhancement write line is high, the bit goes into an 8-bit enhancement word instead. A rising edge on the transfer strobe copies the 20-bit word into a second, holding word. The counters can then be moved between two frequencies by flipping a single select line.

All control lines are asynchronous to the system clock. They pass through a synchronizer, and the block detects their edges in the system clock domain. The frequency select line picks which of the two 20-bit words drives the counters. The enhancement-enable line is active low and gates the enhancement word onto its output. Downstream logic reads the active word as follows: bits [12:0] set the main counter, bits [18:13] set the 6-bit reference divider, and bit 19 is reserved.

Top module: `ctl_shift_bank`

## Requirements
- R1: After reset, the shift word, the holding word and the enhancement word are all zero, so `word_o` is 0 for either select value and `enh_o` is 0.
- R2: Each rising edge of `sclk_i` with `ewr_i` low shifts `sdat_i` into bit 19 of the shift word and moves every bit one place toward bit 0. After 20 edges, the first bit sent is at bit 0.
- R3: A rising edge of `xfer_i` copies the shift word into the holding word. The shift word is unchanged, and the holding word is unchanged at all other times.
- R4: A rising edge of `sclk_i` while `ewr_i` is high shifts `sdat_i` into bit 7 of the enhancement word and moves its bits toward bit 0. The shift word is left unchanged.
- R5: While `enh_n_i` is low, `enh_o` equals the enhancement word. While `enh_n_i` is high, `enh_o` is all zeros.
- R6: `word_o` shows the holding word while `fsel_i` is 1 and the shift word while `fsel_i` is 0.
- R7: When a `sclk_i` rise and an `xfer_i` rise are detected in the same system clock cycle, the holding word receives the shift word as it was before that shift.
- R8: A level of `sclk_i` held high for many system clocks shifts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock line |
| sdat_i | input | 1 | Serial data line |
| xfer_i | input | 1 | Transfer strobe: rising edge copies the shift word into the holding word |
| ewr_i | input | 1 | Steers serial bits into the enhancement word while high |
| fsel_i | input | 1 | 1 selects the holding word, 0 selects the shift word |
| enh_n_i | input | 1 | Active-low enable for the enhancement output |
| word_o | output | 20 | Active 20-bit control word |
| enh_o | output | 8 | Gated enhancement word |

## Verification
The vector table loads a pair of words into the shift and holding words. The pairs use alternating bits, walking ones, all ones and mixed values, and each pair is read back under both select values. A bit-order reversal, a word swap or a lost transfer each give a different readback. Directed tests cover:
- the reset state;
- steering into the enhancement word, with the shift word checked to be untouched;
- the gating of the enhancement output by its enable;
- a serial clock held high for a long time, which must shift only once;
- a serial clock edge and a transfer edge that arrive together, which tells a copy of the pre-shift word apart from a copy of the post-shift word.

// File: rtl/ctl_bank_pkg.sv
package ctl_bank_pkg;
  localparam int WORD_W      = 20;
  localparam int ENH_W       = 8;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_LINES   = 4;
  // bit index of each control line in the synchronized bus
  localparam int LN_SCLK = 0;
  localparam int LN_SDAT = 1;
  localparam int LN_XFER = 2;
  localparam int LN_EWR  = 3;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_d[g];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctl_shreg.sv
module ctl_shreg #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (shift_en_i) q_d = {bit_i, q_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R2 / R4: the new bit enters at the top and the old top bit moves down one place
  p_enter_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (q_o[W-1] == $past(bit_i)) && (q_o[W-2] == $past(q_o[W-1])));
  // R8: no edge means no change
  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(q_o));
endmodule

// File: rtl/ctl_shift_bank.sv
module ctl_shift_bank
  import ctl_bank_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int ENH_BITS  = ENH_W,
  parameter int SYNC_N    = SYNC_STAGES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sdat_i,
  input  logic                 xfer_i,
  input  logic                 ewr_i,
  input  logic                 fsel_i,
  input  logic                 enh_n_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic [ENH_BITS-1:0]  enh_o
);
  localparam int RST_STAGES = 2;

  // reset: asserted asynchronously, released synchronously
  logic [RST_STAGES-1:0] rst_q;
  logic                  rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_q[RST_STAGES-1];

  logic [NUM_LINES-1:0] raw, syn;
  always_comb begin
    raw          = '0;
    raw[LN_SCLK] = sclk_i;
    raw[LN_SDAT] = sdat_i;
    raw[LN_XFER] = xfer_i;
    raw[LN_EWR]  = ewr_i;
  end

  ctl_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_n), .d_i(raw), .q_o(syn)
  );

  // edge detection on the serial clock and the transfer strobe
  logic sclk_prev_q, xfer_prev_q;
  logic sclk_rise, xfer_rise, shift_main, shift_enh;
  always_comb begin
    sclk_rise  = syn[LN_SCLK] & ~sclk_prev_q;
    xfer_rise  = syn[LN_XFER] & ~xfer_prev_q;
    shift_main = sclk_rise & ~syn[LN_EWR];
    shift_enh  = sclk_rise &  syn[LN_EWR];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      xfer_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= syn[LN_SCLK];
      xfer_prev_q <= syn[LN_XFER];
    end
  end

  logic [WORD_BITS-1:0] shift_word;
  logic [ENH_BITS-1:0]  enh_word;

  ctl_shreg #(.W(WORD_BITS)) u_main (
    .clk_i(clk_i), .rst_ni(rst_n), .shift_en_i(shift_main),
    .bit_i(syn[LN_SDAT]), .q_o(shift_word)
  );

  ctl_shreg #(.W(ENH_BITS)) u_enh (
    .clk_i(clk_i), .rst_ni(rst_n), .shift_en_i(shift_enh),
    .bit_i(syn[LN_SDAT]), .q_o(enh_word)
  );

  // holding word: takes the pre-shift contents, even when a shift happens in the same cycle
  logic [WORD_BITS-1:0] hold_q, hold_d;
  always_comb begin
    hold_d = hold_q;
    if (xfer_rise) hold_d = shift_word;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign word_o = fsel_i ? hold_q : shift_word;
  assign enh_o  = enh_n_i ? '0 : enh_word;

  // R3: transfer copies the pre-edge shift word (R7 covers a shift in the same cycle)
  p_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    xfer_rise |=> hold_q == $past(shift_word));
  // R3: holding word changes only on a transfer
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !xfer_rise |=> $stable(hold_q));
  // R4: steering into the enhancement word leaves the shift word alone
  p_steer_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    shift_enh |=> $stable(shift_word));
  // R8: a serial clock rise is a single-cycle pulse
  p_single_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: tb/ctl_shift_bank_tb.sv
module ctl_shift_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, xfer = 1'b0, ewr = 1'b0, fsel = 1'b0, enh_n = 1'b1;
  logic [19:0] word;
  logic [7:0]  enh;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk; // 250 MHz

  ctl_shift_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat), .xfer_i(xfer),
    .ewr_i(ewr), .fsel_i(fsel), .enh_n_i(enh_n), .word_o(word), .enh_o(enh)
  );

  // {word for the holding register, word left in the shift register}
  localparam logic [39:0] VEC [4] = '{
    {20'hAAAAA, 20'h55555},
    {20'h00001, 20'h80000},
    {20'hFFFFF, 20'h00000},
    {20'h3C9E1, 20'hC3216}
  };

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input logic b);
    sdat = b; settle(4);
    sclk = 1'b1; settle(4);
    sclk = 1'b0; settle(4);
  endtask

  task automatic send_word(input logic [19:0] w);
    for (int i = 0; i < 20; i++) ser_bit(w[i]);
  endtask

  task automatic pulse_xfer();
    xfer = 1'b1; settle(4);
    xfer = 1'b0; settle(4);
  endtask

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] p;
    settle(3);
    rst_n = 1'b1;
    settle(5);
    // R1 reset state
    fsel = 1'b0; settle(1); chk("R1 shift word", word, 20'h0);
    fsel = 1'b1; settle(1); chk("R1 holding word", word, 20'h0);
    enh_n = 1'b0; settle(1); chk("R1 enh word", {12'h0, enh}, 20'h0);
    enh_n = 1'b1;

    // R2 R3 R6 vector table
    foreach (VEC[k]) begin
      send_word(VEC[k][39:20]);
      pulse_xfer();
      send_word(VEC[k][19:0]);
      fsel = 1'b0; settle(1); chk("R2/R6 shift word", word, VEC[k][19:0]);
      fsel = 1'b1; settle(1); chk("R3/R6 holding word", word, VEC[k][39:20]);
    end

    // R4 steering, R5 gating
    fsel = 1'b0;
    p = VEC[3][19:0];
    ewr = 1'b1; settle(4);
    for (int i = 0; i < 8; i++) ser_bit(1'(8'hA5 >> i));
    ewr = 1'b0; settle(4);
    chk("R4 shift word untouched", word, p);
    enh_n = 1'b0; settle(1); chk("R5 enh enabled", {12'h0, enh}, 20'h000A5);
    enh_n = 1'b1; settle(1); chk("R5 enh gated", {12'h0, enh}, 20'h0);

    // R8 long high level on the serial clock gives one shift
    sdat = 1'b1; settle(4);
    sclk = 1'b1; settle(40);
    sclk = 1'b0; settle(4);
    p = {1'b1, p[19:1]};
    chk("R8 single shift", word, p);

    // R7 serial edge and transfer edge together
    sdat = 1'b0; settle(4);
    sclk = 1'b1; xfer = 1'b1; settle(6);
    sclk = 1'b0; xfer = 1'b0; settle(4);
    fsel = 1'b1; settle(1); chk("R7 holding gets pre-shift word", word, p);
    fsel = 1'b0; settle(1); chk("R7 shift word advanced", word, {1'b0, p[19:1]});

    // R1 reset again clears everything
    rst_n = 1'b0; settle(2); rst_n = 1'b1; settle(5);
    fsel = 1'b1; settle(1); chk("R1 holding after reset", word, 20'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule